// File: doc/BRIEF.md
# Forwarding ORI Pipeline

This block is a small in-order pipeline with five stages: fetch, decode, execute, memory and writeback. It runs a single arithmetic instruction, the immediate OR, which takes one source register and a 16-bit immediate and writes the result to a destination register. Every other instruction word is treated as a no-op. Instructions come from a small synchronous instruction store. While reset is held, that store is loaded through a programming port.

Decode reads source operands from a 32-entry register file. Decode also compares each source address against the destinations of the two instructions ahead of it. When one matches, decode takes the newer result straight from the execute stage or the memory stage. A dependent instruction can therefore follow its producer in the very next cycle without a bubble. The register file passes a same-cycle writeback through to its read ports, which covers a dependency three instructions apart.

The writeback stage is visible at the ports, and a combinational debug port gives read-only access to any register.

Top module: `ori_fwd_pipe`

## Requirements
- R1: An instruction word with bits [31:26] = 6'b001101 is an immediate OR. Its source register index is bits [25:21], its destination index is bits [20:16] and its immediate is bits [15:0]. It writes the source register's value ORed with the zero-extended immediate to the destination, and this appears on the writeback port.
- R2: When the instruction directly ahead (in execute) writes the register a decoding instruction reads, decode uses the execute result. This has priority over the memory-stage result.
- R3: When only the instruction two ahead (in memory) writes the source register, decode uses the memory-stage value.
- R4: A register file read of the address being written back in the same cycle returns the new data, so a dependency three instructions apart sees the new value.
- R5: Register 0 always reads as zero. An instruction whose destination is register 0 produces no writeback, and neither forwarding path matches on address 0.
- R6: Any word whose bits [31:26] are not 6'b001101, including all zeros, produces no writeback and changes no register.
- R7: One instruction enters per cycle. Writebacks come out in program order, and the writeback of instruction i appears exactly i cycles after that of instruction 0 would.
- R8: The program counter starts at address 0 and stops at the last address of the instruction store. Instructions before the last one are each executed exactly once.
- R9: While reset is held, the writeback port is idle, every register reads zero and both decode operands are zero.
- R10: The debug port shows a written value from the cycle after it appears on the writeback port.
- R11: The program ori $1,$0,0x1100; ori $1,$1,0x0020; ori $1,$1,0x4400; ori $1,$1,0x0044 writes 0x1100, 0x1120, 0x5520 and 0x5564 to register 1 in four consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_we | input | 1 | Write strobe for the instruction store |
| prog_addr | input | ROM_AW | Instruction store write address |
| prog_wdata | input | 32 | Instruction word to store |
| dbg_addr | input | 5 | Register index for the debug view |
| wb_en | output | 1 | A result is written back this cycle |
| wb_addr | output | 5 | Destination register of the writeback |
| wb_data | output | 32 | Value written back |
| dbg_data | output | 32 | Current contents of register dbg_addr |

## Verification
The bench builds the block with its default 32-word instruction store and the full 32-entry register file. At that size a program fills the store, and the counter reaching its halt address falls inside each run. Dense random programs over four registers produce every hazard distance from one to three, including both forwarding stages matching the same register. A second random program spans all 32 register indices, and a directed program covers register 0 and non-ORI words. A sequential model of the program predicts every writeback, its cycle and the final register contents.

// File: rtl/ori_pipe_pkg.sv
package ori_pipe_pkg;
  localparam int XLEN = 32;
  localparam int RAW  = 5;
  localparam int NREG = 1 << RAW;
  localparam int IMMW = 16;
  localparam int OPW  = 6;
  localparam int NRP  = 2;

  localparam logic [OPW-1:0] OPC_ORI = 6'b001101;

  typedef logic [XLEN-1:0] word_t;
  typedef logic [RAW-1:0]  raddr_t;

  // result travelling down the pipe and back to decode
  typedef struct packed {
    logic   we;
    raddr_t addr;
    word_t  data;
  } fwd_t;

  // decoded-to-execute stage contents
  typedef struct packed {
    logic   we;
    raddr_t addr;
    word_t  a;
    word_t  b;
  } exq_t;

  typedef struct packed {
    logic [OPW-1:0]  opc;
    raddr_t          rs;
    raddr_t          rt;
    logic [IMMW-1:0] imm;
  } instr_t;
endpackage

// File: rtl/ori_fetch.sv
module ori_fetch
  import ori_pipe_pkg::*;
#(
  parameter int ROM_AW = 5
) (
  input  logic              clk,
  input  logic              rst_ok,
  input  logic              prog_we,
  input  logic [ROM_AW-1:0] prog_addr,
  input  word_t             prog_wdata,
  output word_t             instr_q,
  output logic [ROM_AW-1:0] pc_q
);
  localparam int DEPTH = 1 << ROM_AW;
  localparam logic [ROM_AW-1:0] PC_LAST = ROM_AW'(DEPTH - 1);

  word_t rom [DEPTH];

  always_ff @(posedge clk) begin
    if (prog_we) rom[prog_addr] <= prog_wdata;
  end

  logic              pc_en;
  logic [ROM_AW-1:0] pc_d;
  word_t             instr_d;

  always_comb begin
    pc_en   = (pc_q != PC_LAST);
    pc_d    = pc_q + 1'b1;
    instr_d = rom[pc_q];
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      pc_q    <= '0;
      instr_q <= '0;
    end else begin
      instr_q <= instr_d;
      if (pc_en) pc_q <= pc_d;
    end
  end
endmodule

// File: rtl/ori_decode.sv
module ori_decode
  import ori_pipe_pkg::*;
(
  input  logic                      rst_ok,
  input  word_t                     instr,
  input  logic [NRP-1:0][XLEN-1:0]  rf_rdata,
  input  fwd_t                      ex_fwd,
  input  fwd_t                      mem_fwd,
  output logic [NRP-1:0]            rd_en,
  output logic [NRP-1:0][RAW-1:0]   rf_raddr,
  output logic [NRP-1:0][XLEN-1:0]  opnd,
  output logic                      dst_we,
  output raddr_t                    dst_addr
);
  instr_t f;
  logic   is_ori;
  word_t  imm_ext;

  always_comb begin
    f           = instr_t'(instr);
    is_ori      = (f.opc == OPC_ORI);
    imm_ext     = {{(XLEN-IMMW){1'b0}}, f.imm};
    rd_en       = {1'b0, is_ori};
    rf_raddr[0] = f.rs;
    rf_raddr[1] = f.rt;
    dst_we      = is_ori && (f.rt != '0);
    dst_addr    = f.rt;
  end

  // youngest producer first, then the older one, then storage, else immediate
  function automatic word_t pick(input logic en, input raddr_t a,
                                 input word_t rf, input word_t imm,
                                 input fwd_t ex, input fwd_t mem);
    logic live;
    live = en && (a != '0);
    if (live && ex.we && (ex.addr == a))        return ex.data;
    else if (live && mem.we && (mem.addr == a)) return mem.data;
    else if (en)                                return rf;
    else                                        return imm;
  endfunction

  for (genvar p = 0; p < NRP; p++) begin : g_opsel
    assign opnd[p] = !rst_ok ? '0
                   : pick(rd_en[p], rf_raddr[p], rf_rdata[p], imm_ext, ex_fwd, mem_fwd);
  end
endmodule

// File: rtl/ori_regfile.sv
module ori_regfile
  import ori_pipe_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_ok,
  input  logic                     we,
  input  raddr_t                   waddr,
  input  word_t                    wdata,
  input  logic [NRP-1:0][RAW-1:0]  raddr,
  output logic [NRP-1:0][XLEN-1:0] rdata,
  input  raddr_t                   dbg_addr,
  output word_t                    dbg_data
);
  logic [NREG-1:0][XLEN-1:0] flat;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (r == 0) begin : g_zero
      assign flat[r] = '0;
    end else begin : g_store
      word_t q;
      logic  wsel;
      assign wsel = we && (waddr == RAW'(r));
      always_ff @(posedge clk or negedge rst_ok) begin
        if (!rst_ok)   q <= '0;
        else if (wsel) q <= wdata;
      end
      assign flat[r] = q;
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0)                 ? '0
                    : (we && (waddr == raddr[p]))      ? wdata
                    : flat[raddr[p]];
  end

  assign dbg_data = flat[dbg_addr];
endmodule

// File: rtl/ori_fwd_pipe.sv
module ori_fwd_pipe
  import ori_pipe_pkg::*;
#(
  parameter int ROM_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [ROM_AW-1:0] prog_addr,
  input  logic [31:0]       prog_wdata,
  input  logic [4:0]        dbg_addr,
  output logic              wb_en,
  output logic [4:0]        wb_addr,
  output logic [31:0]       wb_data,
  output logic [31:0]       dbg_data
);
  // reset: asserted at once, released on a clock edge
  logic rst_s1, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ok <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ok <= rst_s1;
    end
  end

  word_t             fet_instr;
  logic [ROM_AW-1:0] fet_pc;

  ori_fetch #(.ROM_AW(ROM_AW)) u_fetch (
    .clk        (clk),
    .rst_ok     (rst_ok),
    .prog_we    (prog_we),
    .prog_addr  (prog_addr),
    .prog_wdata (prog_wdata),
    .instr_q    (fet_instr),
    .pc_q       (fet_pc)
  );

  logic [NRP-1:0]           id_rd_en;
  logic [NRP-1:0][RAW-1:0]  id_raddr;
  logic [NRP-1:0][XLEN-1:0] id_rdata;
  logic [NRP-1:0][XLEN-1:0] id_opnd;
  logic                     id_we;
  raddr_t                   id_waddr;

  exq_t  ex_q, ex_d;
  word_t ex_res;
  fwd_t  ex_fwd;
  fwd_t  mem_q, mem_d;
  fwd_t  wb_q, wb_d;

  ori_decode u_decode (
    .rst_ok   (rst_ok),
    .instr    (fet_instr),
    .rf_rdata (id_rdata),
    .ex_fwd   (ex_fwd),
    .mem_fwd  (mem_q),
    .rd_en    (id_rd_en),
    .rf_raddr (id_raddr),
    .opnd     (id_opnd),
    .dst_we   (id_we),
    .dst_addr (id_waddr)
  );

  // next-state for the stage registers
  always_comb begin
    ex_d.we    = id_we;
    ex_d.addr  = id_waddr;
    ex_d.a     = id_opnd[0];
    ex_d.b     = id_opnd[1];
    ex_res     = ex_q.a | ex_q.b;
    ex_fwd.we   = ex_q.we;
    ex_fwd.addr = ex_q.addr;
    ex_fwd.data = ex_res;
    mem_d      = ex_fwd;
    wb_d       = mem_q;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      ex_q  <= '0;
      mem_q <= '0;
      wb_q  <= '0;
    end else begin
      ex_q  <= ex_d;
      mem_q <= mem_d;
      wb_q  <= wb_d;
    end
  end

  ori_regfile u_rf (
    .clk      (clk),
    .rst_ok   (rst_ok),
    .we       (wb_q.we),
    .waddr    (wb_q.addr),
    .wdata    (wb_q.data),
    .raddr    (id_raddr),
    .rdata    (id_rdata),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  assign wb_en   = wb_q.we;
  assign wb_addr = wb_q.addr;
  assign wb_data = wb_q.data;
endmodule

// File: rtl/ori_fwd_pipe_chk.sv
module ori_fwd_pipe_chk #(
  parameter int ROM_AW = 5
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              rd_en0,
  input logic [4:0]        id_rs,
  input logic [31:0]       op_a,
  input logic [31:0]       op_b,
  input logic              ex_we,
  input logic [4:0]        ex_addr,
  input logic [31:0]       ex_a,
  input logic [31:0]       ex_b,
  input logic [31:0]       ex_res,
  input logic              mem_we,
  input logic [4:0]        mem_addr,
  input logic [31:0]       mem_data,
  input logic              wb_en,
  input logic [4:0]        wb_addr,
  input logic [31:0]       wb_data,
  input logic [4:0]        dbg_addr,
  input logic [31:0]       dbg_data,
  input logic [ROM_AW-1:0] pc
);
  localparam logic [ROM_AW-1:0] PC_LAST = ROM_AW'((1 << ROM_AW) - 1);

  logic ex_hit, mem_hit, wb_hit;
  assign ex_hit  = rd_en0 && (id_rs != 5'd0) && ex_we  && (ex_addr  == id_rs);
  assign mem_hit = rd_en0 && (id_rs != 5'd0) && mem_we && (mem_addr == id_rs);
  assign wb_hit  = rd_en0 && (id_rs != 5'd0) && wb_en  && (wb_addr  == id_rs);

  // R2
  ex_fwd_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ex_hit |=> ex_a == $past(ex_res));

  // R3
  mem_fwd_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (mem_hit && !ex_hit) |=> ex_a == $past(mem_data));

  // R4
  wb_thru_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wb_hit && !ex_hit && !mem_hit) |=> ex_a == $past(wb_data));

  // R1
  imm_zext_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ex_we |-> ex_b[31:16] == 16'd0);

  // R5
  r0_read_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (dbg_addr == 5'd0) |-> dbg_data == 32'd0);

  // R5
  r0_nowb_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    wb_en |-> wb_addr != 5'd0);

  // R7
  ex_to_mem_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ex_we |=> mem_we && mem_data == $past(ex_res));

  // R7
  mem_to_wb_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    mem_we |=> wb_en && wb_data == $past(mem_data));

  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (pc == PC_LAST) |=> pc == PC_LAST);

  // R10
  dbg_update_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wb_en && wb_addr == dbg_addr) |=> (!$stable(dbg_addr) || dbg_data == $past(wb_data)));

  // R9
  always_ff @(posedge clk) begin
    if (!rst_ok) begin
      rst_opnd_chk: assert (op_a == 32'd0 && op_b == 32'd0 && !wb_en);
    end
  end
endmodule

bind ori_fwd_pipe ori_fwd_pipe_chk #(.ROM_AW(ROM_AW)) u_chk (
  .clk      (clk),
  .rst_ok   (rst_ok),
  .rd_en0   (id_rd_en[0]),
  .id_rs    (id_raddr[0]),
  .op_a     (id_opnd[0]),
  .op_b     (id_opnd[1]),
  .ex_we    (ex_q.we),
  .ex_addr  (ex_q.addr),
  .ex_a     (ex_q.a),
  .ex_b     (ex_q.b),
  .ex_res   (ex_res),
  .mem_we   (mem_q.we),
  .mem_addr (mem_q.addr),
  .mem_data (mem_q.data),
  .wb_en    (wb_en),
  .wb_addr  (wb_addr),
  .wb_data  (wb_data),
  .dbg_addr (dbg_addr),
  .dbg_data (dbg_data),
  .pc       (fet_pc)
);

// File: tb/ori_fwd_pipe_test.sv
`timescale 1ns/1ps
module ori_fwd_pipe_test;
  localparam int ROM_AW = 5;
  localparam int DEPTH  = 1 << ROM_AW;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              prog_we;
  logic [ROM_AW-1:0] prog_addr;
  logic [31:0]       prog_wdata;
  logic [4:0]        dbg_addr;
  logic              wb_en;
  logic [4:0]        wb_addr;
  logic [31:0]       wb_data;
  logic [31:0]       dbg_data;

  always #2 clk = ~clk;

  ori_fwd_pipe #(.ROM_AW(ROM_AW)) uut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_wdata(prog_wdata), .dbg_addr(dbg_addr), .wb_en(wb_en),
    .wb_addr(wb_addr), .wb_data(wb_data), .dbg_data(dbg_data)
  );

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] prog  [DEPTH];
  logic [31:0] model [32];
  logic [4:0]  exp_a [DEPTH];
  logic [31:0] exp_d [DEPTH];
  int          exp_i [DEPTH];
  int          exp_n;
  logic [31:0] seed;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ori_w(input int rs, input int rt, input int imm);
    return {6'b001101, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] lcg();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  // mode 0: the four-step R11 program; 1: dense over r0..r3; 2: all registers; 3: directed r0 / non-ORI
  task automatic fill(input int mode);
    for (int i = 0; i < DEPTH; i++) prog[i] = 32'd0;
    case (mode)
      0: begin
        prog[0] = ori_w(0, 1, 16'h1100);
        prog[1] = ori_w(1, 1, 16'h0020);
        prog[2] = ori_w(1, 1, 16'h4400);
        prog[3] = ori_w(1, 1, 16'h0044);
      end
      1, 2: begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          logic [31:0] r;
          r = lcg();
          if (r[30:28] == 3'd0)      prog[i] = 32'd0;
          else if (r[30:28] == 3'd1) prog[i] = {6'b001111, r[25:0]};
          else if (mode == 1)        prog[i] = ori_w(int'(r[17:16]), int'(r[19:18]), int'({r[31:24], r[7:0]}));
          else                       prog[i] = ori_w(int'(r[20:16]), int'(r[25:21]), int'({r[31:26], r[9:0]}));
        end
      end
      default: begin
        prog[0] = ori_w(0, 0, 16'hFFFF);
        prog[1] = ori_w(0, 2, 16'h0005);
        prog[2] = ori_w(2, 0, 16'h0001);
        prog[3] = ori_w(0, 3, 16'h0000);
        prog[4] = {6'b001111, 5'd2, 5'd2, 16'hFFFF};
        prog[5] = ori_w(2, 4, 16'h0000);
        prog[6] = {6'b000000, 5'd0, 5'd5, 16'h1234};
        prog[7] = ori_w(5, 6, 16'h0000);
        prog[8] = ori_w(0, 5, 16'h00A0);
        prog[9] = ori_w(5, 7, 16'h000A);
      end
    endcase
  endtask

  // sequential reference: each instruction completes before the next
  task automatic build_model();
    for (int r = 0; r < 32; r++) model[r] = 32'd0;
    exp_n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [31:0] w, v;
      w = prog[i];
      if (w[31:26] == 6'b001101) begin
        v = model[w[25:21]] | {16'd0, w[15:0]};
        if (w[20:16] != 5'd0) begin
          model[w[20:16]] = v;
          exp_a[exp_n] = w[20:16];
          exp_d[exp_n] = v;
          exp_i[exp_n] = i;
          exp_n++;
        end
      end
    end
  endtask

  task automatic run_prog(input bit is_spec);
    int k, t0;
    bit prev_hit;
    logic [31:0] prev_d;
    logic [31:0] spec [4];
    spec[0] = 32'h1100; spec[1] = 32'h1120; spec[2] = 32'h5520; spec[3] = 32'h5564;

    @(negedge clk);
    rst_n = 1'b0;
    prog_we = 1'b0;
    repeat (2) @(negedge clk);
    // R9: idle writeback and cleared registers under reset
    check("R9 wb_en in reset", {31'd0, wb_en}, 32'd0);
    for (int a = 0; a < 32; a++) begin
      dbg_addr = 5'(a);
      #0.04;
      check("R9 register cleared in reset", dbg_data, 32'd0);
    end
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      prog_we = 1'b1;
      prog_addr = ROM_AW'(i);
      prog_wdata = prog[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
    build_model();
    dbg_addr = 5'd1;
    rst_n = 1'b1;

    k = 0; t0 = 0; prev_hit = 1'b0; prev_d = 32'd0;
    repeat (DEPTH + 12) begin
      @(negedge clk);
      if (prev_hit) check("R10 debug view after writeback", dbg_data, prev_d);
      prev_hit = 1'b0;
      if (wb_en) begin
        if (k < exp_n) begin
          check("R1/R5/R6 writeback address", {27'd0, wb_addr}, {27'd0, exp_a[k]});
          check("R1/R2/R3/R4 writeback data", wb_data, exp_d[k]);
          if (is_spec && k < 4) check("R11 register 1 sequence", wb_data, spec[k]);
          if (k == 0) t0 = cyc - exp_i[0];
          else        check("R7 writeback cycle", cyc, t0 + exp_i[k]);
          if (wb_addr == 5'd1) begin
            prev_hit = 1'b1;
            prev_d = wb_data;
          end
        end else begin
          n_run++;
          n_fail++;
          $display("FAIL R8 extra writeback actual=%h expected=none", wb_data);
        end
        k++;
      end
    end
    check("R7/R8 writeback count", k, exp_n);
    // R1/R5: final contents of every register through the debug port
    for (int a = 0; a < 32; a++) begin
      dbg_addr = 5'(a);
      #0.04;
      check("R1/R5 final register", dbg_data, model[a]);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    prog_we = 1'b0;
    prog_addr = '0;
    prog_wdata = 32'd0;
    dbg_addr = 5'd0;
    seed = 32'h1234_5678;

    fill(0); run_prog(1'b1);
    fill(1); run_prog(1'b0);
    fill(1); run_prog(1'b0);
    fill(2); run_prog(1'b0);
    fill(3); run_prog(1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R7 watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule